// File: doc/BRIEF.md
# Offset-Adding Relative Jump Address Generator

This block produces a memory address as the sum of a base counter and a separately loaded offset register. A relative jump therefore costs one offset load instead of a trip through the ALU. The base counter and the offset register both load from the shared data bus.

The base counter has four controls: clear, load, count up and count down. The offset register has its own load strobe. A 16-bit adder forms the presented address. When the sum leaves the address range, an out-of-bounds flag is raised. The flag comes from the adder, never from the counter wrapping.

A bypass input presents the raw counter value instead of the sum. This mode is meant for instances that do not use offsets. The address and the flag are combinational from the two registers and the bypass input.

Top module: `rel_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after its release, the base counter and the offset register are zero, so `addr_out` is 0000 and `out_of_bounds` is 0.
- R2: At a rising clock edge with `base_clear` high, the base counter becomes 0000, whatever the other counter controls are.
- R3: At a rising clock edge with `base_load` high and `base_clear` low, the base counter takes the value of `bus_data`.
- R4: With only `base_up` asserted among the counter controls, the counter advances by one per edge, modulo 2^16, so FFFF wraps to 0000.
- R5: With only `base_down` asserted, the counter falls by one per edge, modulo 2^16, so 0000 wraps to FFFF. With both `base_up` and `base_down` high (and no clear or load), the counter holds.
- R6: At a rising edge with `ofs_load` high, the offset register takes `bus_data`. This happens independently of the counter controls, including in the same cycle as a counter load from the same bus value.
- R7: With `ofs_load` low, the offset register holds its value, whatever the counter controls do.
- R8: With `bypass` low, `addr_out` equals (counter + offset) mod 2^16 in the same cycle the registers hold those values.
- R9: With `bypass` low, the offset is read as a 16-bit two's-complement number (bit 15 set means negative). `out_of_bounds` is 1 exactly when counter + offset, taken as a signed integer, is below 0 or above 65535. Counter wrap alone never raises it.
- R10: With `bypass` high, `addr_out` equals the raw counter value and `out_of_bounds` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 16 | Shared data bus value for counter and offset loads |
| base_clear | input | 1 | Clear the base counter (highest priority) |
| base_load | input | 1 | Load the base counter from `bus_data` |
| base_up | input | 1 | Increment the base counter |
| base_down | input | 1 | Decrement the base counter |
| ofs_load | input | 1 | Load the offset register from `bus_data` |
| bypass | input | 1 | Present the raw counter instead of the sum |
| addr_out | output | 16 | Presented memory address |
| out_of_bounds | output | 1 | Sum left the address range |

## Verification
The bench targets the sum edges. It uses a positive offset that lands exactly on FFFF (no flag) and one that lands one past it (flag, address 0000). It uses a negative offset that lands exactly on 0000 (no flag) and one that lands one below it (flag, address FFFF).

A design that took the flag from the raw carry, without the offset sign, would flag every valid backward jump. A design that took the flag from counter wrap would flag the plain FFFF-to-0000 increment, which is also checked.

Counter control priority is exercised: clear over load, load over counting, and simultaneous up and down. A swapped priority shows up as a wrong address. The bench also loads the offset in the same cycle as a counter load, so an offset register wired to the counter strobes, or one that fails to hold, produces a wrong sum.

// File: rtl/rel_addr_pkg.sv
// Shared definitions for the relative jump address generator.
// Assumes a single clock domain; all widths come from ADDR_W_DEF unless overridden.
package rel_addr_pkg;
    localparam int ADDR_W_DEF = 16;

    // Resolved action of the base counter for one clock edge.
    typedef enum logic [2:0] {
        CNT_HOLD  = 3'd0,
        CNT_CLEAR = 3'd1,
        CNT_LOAD  = 3'd2,
        CNT_UP    = 3'd3,
        CNT_DOWN  = 3'd4
    } cnt_op_e;
endpackage

// File: rtl/base_counter.sv
// Base counter: clear, parallel load, increment, decrement.
// Priority is clear > load > count; up and down together hold.
// Assumes a synchronous active-low reset to zero.
module base_counter
    import rel_addr_pkg::*;
#(
    parameter int W = ADDR_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         clr,
    input  logic         load,
    input  logic         up,
    input  logic         down,
    output logic [W-1:0] count
);
    cnt_op_e op;

    // Resolve the competing controls into a single action.
    always_comb begin
        if (clr)                op = CNT_CLEAR;
        else if (load)          op = CNT_LOAD;
        else if (up && !down)   op = CNT_UP;
        else if (down && !up)   op = CNT_DOWN;
        else                    op = CNT_HOLD;
    end

    // Apply the resolved action at the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (op)
                CNT_CLEAR: count <= '0;
                CNT_LOAD:  count <= din;
                CNT_UP:    count <= count + W'(1);
                CNT_DOWN:  count <= count - W'(1);
                default:   count <= count;
            endcase
        end
    end
endmodule

// File: rtl/offset_reg.sv
// Offset register: holds the jump displacement, loaded by its own strobe.
// Assumes a synchronous active-low reset to zero.
module offset_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         load,
    output logic [W-1:0] q
);
    // Capture the bus on load, otherwise keep the stored offset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= din;
    end
endmodule

// File: rtl/offset_adder.sv
// Adds an unsigned base to a two's-complement offset and reports range exits.
// A positive offset with a carry out ran past the top; a negative offset
// without a carry out fell below zero. Purely combinational.
module offset_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] ofs,
    output logic [W-1:0] sum,
    output logic         over,
    output logic         under
);
    logic carry;

    // Raw addition with carry, then classify by the offset sign bit.
    always_comb begin
        {carry, sum} = {1'b0, base} + {1'b0, ofs};
        over  = !ofs[W-1] &&  carry;
        under =  ofs[W-1] && !carry;
    end
endmodule

// File: rtl/rel_addr_gen.sv
// Relative jump address generator: base counter plus offset register feeding
// an adder, with a bypass that presents the raw counter. Outputs are
// combinational from the registers and the bypass input.
module rel_addr_gen
    import rel_addr_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_data,
    input  logic              base_clear,
    input  logic              base_load,
    input  logic              base_up,
    input  logic              base_down,
    input  logic              ofs_load,
    input  logic              bypass,
    output logic [ADDR_W-1:0] addr_out,
    output logic              out_of_bounds
);
    logic [ADDR_W-1:0] cnt_q;
    logic [ADDR_W-1:0] ofs_q;
    logic [ADDR_W-1:0] sum;
    logic              sum_over;
    logic              sum_under;

    base_counter #(.W(ADDR_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (bus_data),
        .clr   (base_clear),
        .load  (base_load),
        .up    (base_up),
        .down  (base_down),
        .count (cnt_q)
    );

    offset_reg #(.W(ADDR_W)) u_ofs (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (bus_data),
        .load  (ofs_load),
        .q     (ofs_q)
    );

    offset_adder #(.W(ADDR_W)) u_add (
        .base  (cnt_q),
        .ofs   (ofs_q),
        .sum   (sum),
        .over  (sum_over),
        .under (sum_under)
    );

    // Select the presented address and mask the range flag in bypass.
    always_comb begin
        addr_out      = bypass ? cnt_q : sum;
        out_of_bounds = !bypass && (sum_over || sum_under);
    end
endmodule

// File: rtl/rel_addr_gen_chk.sv
// Property checker for rel_addr_gen, attached by bind below.
module rel_addr_gen_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] bus_data,
    input logic         base_clear,
    input logic         base_load,
    input logic         base_up,
    input logic         base_down,
    input logic         ofs_load,
    input logic         bypass,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] ofs_q,
    input logic [W-1:0] addr_out,
    input logic         out_of_bounds
);
    // R2
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_clear |=> cnt_q == '0);

    // R3
    load_takes_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_load && !base_clear) |=> cnt_q == $past(bus_data));

    // R4
    count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_up && !base_down && !base_load && !base_clear)
        |=> cnt_q == $past(cnt_q) + W'(1));

    // R5
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_down && !base_up && !base_load && !base_clear)
        |=> cnt_q == $past(cnt_q) - W'(1));

    // R6
    ofs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_load |=> ofs_q == $past(bus_data));

    // R7
    ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ofs_load |=> $stable(ofs_q));

    // R10
    bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (addr_out == cnt_q && !out_of_bounds));

    // R9
    oob_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_bounds |-> (!bypass && (ofs_q[W-1] ? (addr_out > cnt_q)
                                                  : (addr_out < cnt_q))));
endmodule

bind rel_addr_gen rel_addr_gen_chk #(.W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_data      (bus_data),
    .base_clear    (base_clear),
    .base_load     (base_load),
    .base_up       (base_up),
    .base_down     (base_down),
    .ofs_load      (ofs_load),
    .bypass        (bypass),
    .cnt_q         (cnt_q),
    .ofs_q         (ofs_q),
    .addr_out      (addr_out),
    .out_of_bounds (out_of_bounds)
);

// File: tb/tb_rel_addr_gen.sv
`timescale 1ns/1ps
module tb_rel_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_data = '0;
    logic        base_clear = 0, base_load = 0, base_up = 0, base_down = 0;
    logic        ofs_load = 0, bypass = 0;
    logic [15:0] addr_out;
    logic        out_of_bounds;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_cnt = '0;
    logic [15:0] m_ofs = '0;

    always #2 clk = ~clk;

    rel_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
        .base_clear(base_clear), .base_load(base_load),
        .base_up(base_up), .base_down(base_down),
        .ofs_load(ofs_load), .bypass(bypass),
        .addr_out(addr_out), .out_of_bounds(out_of_bounds)
    );

    function automatic int signed_sum(logic [15:0] c, logic [15:0] o);
        int so;
        so = o[15] ? int'(o) - 65536 : int'(o);
        return int'(c) + so;
    endfunction

    function automatic logic [15:0] exp_addr(logic byp, logic [15:0] c, logic [15:0] o);
        int s;
        if (byp) return c;
        s = signed_sum(c, o);
        if (s < 0) s = s + 65536;
        if (s > 65535) s = s - 65536;
        return 16'(s);
    endfunction

    function automatic logic exp_oob(logic byp, logic [15:0] c, logic [15:0] o);
        int s;
        if (byp) return 1'b0;
        s = signed_sum(c, o);
        return (s < 0) || (s > 65535);
    endfunction

    task automatic check(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (cnt=%h ofs=%h byp=%0d)",
                     tag, got, exp, m_cnt, m_ofs, bypass);
        end
    endtask

    // Drive one cycle of controls, check outputs mid-cycle, update model.
    task automatic step(string tag, logic clr, logic ld, logic up, logic dn,
                        logic ol, logic byp, logic [15:0] d);
        @(negedge clk);
        base_clear = clr; base_load = ld; base_up = up; base_down = dn;
        ofs_load = ol; bypass = byp; bus_data = d;
        #1;
        check({tag, byp ? " R10 addr" : " R8 addr"}, int'(addr_out),
              int'(exp_addr(byp, m_cnt, m_ofs)));
        check({tag, byp ? " R10 flag" : " R9 flag"}, int'(out_of_bounds),
              int'(exp_oob(byp, m_cnt, m_ofs)));
        @(posedge clk);
        if (clr)            m_cnt = '0;
        else if (ld)        m_cnt = d;
        else if (up && !dn) m_cnt = m_cnt + 16'd1;
        else if (dn && !up) m_cnt = m_cnt - 16'd1;
        if (ol) m_ofs = d;
    endtask

    // Load both registers, then observe with bypass low.
    task automatic setup(string tag, logic [15:0] c, logic [15:0] o);
        step(tag, 0, 1, 0, 0, 0, 1, c);
        step(tag, 0, 0, 0, 0, 1, 1, o);
        step(tag, 0, 0, 0, 0, 0, 0, 16'h0);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        // R1: outputs while reset is held
        @(negedge clk);
        check("R1 addr in reset", int'(addr_out), 0);
        check("R1 flag in reset", int'(out_of_bounds), 0);
        rst_n = 1'b1;
        step("R1", 0, 0, 0, 0, 0, 0, 16'h0);

        // R3 load, R2 clear beats load
        step("R3", 0, 1, 1, 0, 0, 1, 16'h1234);
        step("R3", 0, 0, 0, 0, 0, 1, 16'h0);
        step("R2", 1, 1, 1, 0, 0, 1, 16'hBEEF);
        step("R2", 0, 0, 0, 0, 0, 1, 16'h0);

        // R4 wrap up, no flag from counter wrap (R9)
        step("R4", 0, 1, 0, 0, 0, 1, 16'hFFFF);
        step("R4", 0, 0, 1, 0, 0, 0, 16'h0);
        step("R4 R9", 0, 0, 0, 0, 0, 0, 16'h0);
        // R5 wrap down and up+down hold
        step("R5", 0, 0, 0, 1, 0, 1, 16'h0);
        step("R5", 0, 0, 1, 1, 0, 1, 16'h0);
        step("R5", 0, 0, 0, 0, 0, 1, 16'h0);

        // R6 offset and counter load in same cycle
        step("R6", 0, 1, 0, 0, 1, 0, 16'h0100);
        step("R6", 0, 0, 0, 0, 0, 0, 16'h0);
        // R7 counter activity leaves offset untouched
        step("R7", 0, 0, 1, 0, 0, 0, 16'h5555);
        step("R7", 1, 0, 0, 0, 0, 0, 16'h5555);
        step("R7", 0, 0, 0, 0, 0, 0, 16'h0);

        // R9 boundaries
        setup("R9 top exact", 16'hFFF0, 16'h000F);
        setup("R9 top over", 16'hFFF0, 16'h0010);
        setup("R9 bottom exact", 16'h0005, 16'hFFFB);
        setup("R9 bottom under", 16'h0005, 16'hFFFA);
        setup("R9 max neg", 16'h7FFF, 16'h8000);
        step("R10 mask", 0, 0, 0, 0, 0, 1, 16'h0);

        // Random traffic with biased bus values
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            int pick;
            pick = int'($urandom_range(0, 5));
            case (pick)
                0: d = 16'h0000;
                1: d = 16'hFFFF;
                2: d = 16'h8000;
                3: d = 16'h7FFF;
                default: d = 16'($urandom);
            endcase
            step("rand", ($urandom_range(0, 15) == 0), ($urandom_range(0, 5) == 0),
                 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 3) == 0), d);
        end
        step("final", 0, 0, 0, 0, 0, 0, 16'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule